// File: doc/BRIEF.md
# Debug Command Stream Parser

This block sits behind a JTAG TAP controller and turns the bits shifted through a debug data register into decoded debug requests. The TAP reports when it is in the shift-data state and when the debug instruction is loaded, and passes on the TDI value sampled on the test clock. The parser packs those bits into bytes, least significant bit first. It hands a byte onward after every eighth shift clock, and no update-data state is needed for that. The first byte of a frame is the command opcode. The parser then collects the argument bytes that opcode needs, most significant byte first, and raises a one-cycle request strobe together with the decoded fields.

The frame length depends on the opcode:

- A memory access carries a 32-bit address. A memory write also carries 1, 2 or 4 data bytes.
- A register access carries an 8-bit register number. A register write also carries 4 data bytes.
- A CSR access carries a 16-bit selector that holds a bank and a CSR number. A CSR write also carries 4 data bytes.
- A control command carries no argument bytes.

Leaving the shift state, or deselecting the debug instruction, drops any partial byte and any partial frame. A corrupted stream is therefore realigned at the next scan.

The request side has no back-pressure, because the shift clock cannot be stalled. The consumer must accept every `req_valid` pulse in the cycle it occurs. The fields stay stable until the next pulse.

Top module: `dbg_cmd_parser`

## Requirements
- R1: After reset, `req_valid` and `req_err` are 0, and `req_opcode`, `req_sel` and `req_wdata` are 0.
- R2: Bits taken while `shift_en` and `dbg_sel` are both high are packed into bytes, first bit into bit 0. Every 8 such clocks complete one byte. Frames follow back to back in one scan, and a request is issued without leaving the shift state.
- R3: The first byte of a frame is the opcode. The control opcodes 0x30 to 0x36 take no argument bytes. Their request is issued right after the opcode byte, with `req_sel` and `req_wdata` equal to 0.
- R4: Memory reads take 4 address bytes, most significant first, into `req_sel`. The opcodes are 0x10 (byte), 0x11 (halfword) and 0x12 (word).
- R5: Memory writes take 4 address bytes and then 1, 2 or 4 data bytes, most significant first. The opcodes are 0x18 (byte), 0x19 (halfword) and 0x1A (word). The data goes zero-extended into `req_wdata`.
- R6: Register read 0x20 takes one register-number byte into `req_sel[7:0]`, with the upper bits 0. Register write 0x21 takes that byte and then 4 data bytes.
- R7: CSR read 0x22 takes a 2-byte selector into `req_sel[15:0]`. `req_bank` equals selector bits 4:0 and `req_csr` equals selector bits 15:5. CSR write 0x23 takes the selector and then 4 data bytes.
- R8: An opcode outside the table gives `req_valid` with `req_err` high, zero arguments, and `req_sel` and `req_wdata` equal to 0. The next byte is taken as a new opcode.
- R9: Dropping `shift_en` discards the partial byte and the partial frame. The next scan starts with a fresh opcode byte.
- R10: Bits shifted while `dbg_sel` is low are ignored and clear any partial byte and frame.
- R11: `req_valid` lasts exactly one cycle per frame, and the request fields hold their value until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset |
| shift_en | input | 1 | TAP is in the shift-data state |
| dbg_sel | input | 1 | Debug instruction is selected |
| tdi | input | 1 | Sampled serial input bit |
| req_valid | output | 1 | One-cycle request strobe |
| req_err | output | 1 | Unknown opcode, valid with req_valid |
| req_opcode | output | 8 | Command opcode |
| req_sel | output | 32 | Address, register number or CSR selector |
| req_wdata | output | 32 | Write data, zero-extended |
| req_bank | output | 5 | CSR bank, selector bits 4:0 |
| req_csr | output | 11 | CSR number, selector bits 15:5 |

## Verification
Some rules are checked by the assertions on every cycle:

- Byte strobes are never adjacent.
- A byte strobe follows only a cycle in which bits were taken.
- A request strobe follows a byte strobe and lasts one cycle.
- An error always comes with a request that carries empty fields.
- Losing the shift or debug selection always empties the frame state.

Other behaviour only the directed scenarios can show:

- The argument count for each opcode.
- The byte order of addresses and data.
- The CSR field split.
- Recovery after a scan is cut short mid-byte or mid-frame.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 32;
  localparam int DATA_W = 32;
  localparam int BANK_W = 5;
  localparam int CSEL_W = 16;
  localparam int CNT_W  = 4;

  localparam logic [7:0] OP_RD_B   = 8'h10;
  localparam logic [7:0] OP_RD_H   = 8'h11;
  localparam logic [7:0] OP_RD_W   = 8'h12;
  localparam logic [7:0] OP_WR_B   = 8'h18;
  localparam logic [7:0] OP_WR_H   = 8'h19;
  localparam logic [7:0] OP_WR_W   = 8'h1A;
  localparam logic [7:0] OP_RD_REG = 8'h20;
  localparam logic [7:0] OP_WR_REG = 8'h21;
  localparam logic [7:0] OP_RD_CSR = 8'h22;
  localparam logic [7:0] OP_WR_CSR = 8'h23;
  localparam logic [7:0] OP_DBG_ON = 8'h30;
  localparam logic [7:0] OP_DBG_OFF= 8'h31;
  localparam logic [7:0] OP_RST_ON = 8'h32;
  localparam logic [7:0] OP_RST_OFF= 8'h33;
  localparam logic [7:0] OP_HALT   = 8'h34;
  localparam logic [7:0] OP_RESUME = 8'h35;
  localparam logic [7:0] OP_FLUSH  = 8'h36;

  typedef struct packed {
    logic             known;
    logic [CNT_W-1:0] sel_n;   // selector bytes
    logic [CNT_W-1:0] tot_n;   // all argument bytes
  } op_info_t;

  function automatic op_info_t op_lookup(input logic [7:0] op);
    op_info_t r;
    r = '{known: 1'b1, sel_n: '0, tot_n: '0};
    case (op)
      OP_RD_B, OP_RD_H, OP_RD_W: begin r.sel_n = 4'd4; r.tot_n = 4'd4; end
      OP_WR_B:   begin r.sel_n = 4'd4; r.tot_n = 4'd5; end
      OP_WR_H:   begin r.sel_n = 4'd4; r.tot_n = 4'd6; end
      OP_WR_W:   begin r.sel_n = 4'd4; r.tot_n = 4'd8; end
      OP_RD_REG: begin r.sel_n = 4'd1; r.tot_n = 4'd1; end
      OP_WR_REG: begin r.sel_n = 4'd1; r.tot_n = 4'd5; end
      OP_RD_CSR: begin r.sel_n = 4'd2; r.tot_n = 4'd2; end
      OP_WR_CSR: begin r.sel_n = 4'd2; r.tot_n = 4'd6; end
      OP_DBG_ON, OP_DBG_OFF, OP_RST_ON, OP_RST_OFF,
      OP_HALT, OP_RESUME, OP_FLUSH: r.known = 1'b1;
      default:   r.known = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dbg_byte_asm.sv
module dbg_byte_asm #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         tdi,
  output logic [W-1:0] byte_q,
  output logic         byte_vld
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      byte_q   <= '0;
      byte_vld <= 1'b0;
    end else if (!take) begin
      cnt      <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_q   <= {tdi, byte_q[W-1:1]};
      byte_vld <= (cnt == LAST);
      cnt      <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // R2
  byte_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
  // R10
  byte_from_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(take));
endmodule

// File: rtl/dbg_frame_ctrl.sv
module dbg_frame_ctrl
  import dbg_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              byte_vld,
  output logic              req_valid,
  output logic              req_err,
  output logic [7:0]        req_opcode,
  output logic [SEL_W-1:0]  req_sel,
  output logic [DATA_W-1:0] req_wdata
);
  logic              in_args;
  logic [7:0]        op_q;
  logic [CNT_W-1:0]  sel_n_q, tot_n_q, got;
  logic [SEL_W-1:0]  sel_acc, sel_nx;
  logic [DATA_W-1:0] dat_acc, dat_nx;
  op_info_t          info_nx;
  logic              done;

  always_comb begin
    info_nx = op_lookup(byte_in);
    sel_nx  = sel_acc;
    dat_nx  = dat_acc;
    done    = 1'b0;
    if (byte_vld) begin
      if (!in_args) begin
        sel_nx = '0;
        dat_nx = '0;
        done   = (info_nx.tot_n == '0);
      end else begin
        if (got < sel_n_q) sel_nx = {sel_acc[SEL_W-BYTE_W-1:0], byte_in};
        else               dat_nx = {dat_acc[DATA_W-BYTE_W-1:0], byte_in};
        done = (CNT_W'(got + 1'b1) == tot_n_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_args    <= 1'b0;
      op_q       <= '0;
      sel_n_q    <= '0;
      tot_n_q    <= '0;
      got        <= '0;
      sel_acc    <= '0;
      dat_acc    <= '0;
      req_valid  <= 1'b0;
      req_err    <= 1'b0;
      req_opcode <= '0;
      req_sel    <= '0;
      req_wdata  <= '0;
    end else begin
      req_valid <= 1'b0;
      req_err   <= 1'b0;
      if (byte_vld) begin
        sel_acc <= sel_nx;
        dat_acc <= dat_nx;
        in_args <= !done;
        if (!in_args) begin
          op_q    <= byte_in;
          sel_n_q <= info_nx.sel_n;
          tot_n_q <= info_nx.tot_n;
          got     <= '0;
        end else begin
          got <= got + 1'b1;
        end
        if (done) begin
          req_valid  <= 1'b1;
          req_err    <= !in_args && !info_nx.known;
          req_opcode <= in_args ? op_q : byte_in;
          req_sel    <= sel_nx;
          req_wdata  <= dat_nx;
        end
      end
      if (!take) in_args <= 1'b0;
    end
  end

  // R8
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> req_valid);
  // R8
  err_empty_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (req_sel == '0 && req_wdata == '0));
  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  // R2
  valid_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(byte_vld));
  // R9
  abort_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !in_args);
endmodule

// File: rtl/dbg_cmd_parser.sv
module dbg_cmd_parser
  import dbg_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              dbg_sel,
  input  logic              tdi,
  output logic              req_valid,
  output logic              req_err,
  output logic [7:0]        req_opcode,
  output logic [SEL_W-1:0]  req_sel,
  output logic [DATA_W-1:0] req_wdata,
  output logic [BANK_W-1:0] req_bank,
  output logic [CSEL_W-BANK_W-1:0] req_csr
);
  logic              take;
  logic [BYTE_W-1:0] byte_q;
  logic              byte_vld;

  assign take = shift_en & dbg_sel;

  dbg_byte_asm #(.W(BYTE_W)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .tdi      (tdi),
    .byte_q   (byte_q),
    .byte_vld (byte_vld)
  );

  dbg_frame_ctrl u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .byte_in    (byte_q),
    .byte_vld   (byte_vld),
    .req_valid  (req_valid),
    .req_err    (req_err),
    .req_opcode (req_opcode),
    .req_sel    (req_sel),
    .req_wdata  (req_wdata)
  );

  assign req_bank = req_sel[BANK_W-1:0];
  assign req_csr  = req_sel[CSEL_W-1:BANK_W];
endmodule

// File: tb/dbg_cmd_parser_bench.sv
module dbg_cmd_parser_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, shift_en = 1'b0, dbg_sel = 1'b0, tdi = 1'b0;
  logic        req_valid, req_err;
  logic [7:0]  req_opcode;
  logic [31:0] req_sel, req_wdata;
  logic [4:0]  req_bank;
  logic [10:0] req_csr;

  dbg_cmd_parser u_dbg_cmd_parser (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .dbg_sel(dbg_sel), .tdi(tdi),
    .req_valid(req_valid), .req_err(req_err), .req_opcode(req_opcode),
    .req_sel(req_sel), .req_wdata(req_wdata), .req_bank(req_bank), .req_csr(req_csr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, vcnt = 0;
  logic [7:0]  log_op   [0:63];
  logic        log_err  [0:63];
  logic        log_sh   [0:63];
  logic [31:0] log_sel  [0:63];
  logic [31:0] log_dat  [0:63];
  logic [7:0]  fb [0:9];

  always begin
    @(posedge clk);
    #1;
    if (rst_n && req_valid) begin
      if (vcnt < 64) begin
        log_op[vcnt]  = req_opcode;
        log_err[vcnt] = req_err;
        log_sh[vcnt]  = shift_en;
        log_sel[vcnt] = req_sel;
        log_dat[vcnt] = req_wdata;
      end
      vcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic shift_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      shift_en = 1'b1;
      tdi = b[i];
    end
  endtask

  task automatic end_scan();
    @(negedge clk);
    shift_en = 1'b0;
    tdi = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input int n);
    for (int i = 0; i < n; i++) shift_byte(fb[i]);
    end_scan();
  endtask

  task automatic expect_req(input string tag, input int idx, input logic [7:0] op,
                            input logic err, input logic [31:0] sel, input logic [31:0] dat);
    chk(log_op[idx] == op, {tag, " opcode"}, 64'(log_op[idx]), 64'(op));
    chk(log_err[idx] == err, {tag, " err"}, 64'(log_err[idx]), 64'(err));
    chk(log_sel[idx] == sel, {tag, " sel"}, 64'(log_sel[idx]), 64'(sel));
    chk(log_dat[idx] == dat, {tag, " wdata"}, 64'(log_dat[idx]), 64'(dat));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_valid == 1'b0 && req_err == 1'b0, "R1 strobes", 64'({req_valid, req_err}), 64'd0);
    chk(req_opcode == 8'd0 && req_sel == 32'd0 && req_wdata == 32'd0, "R1 fields",
        {req_sel, req_wdata}, 64'd0);
  endtask

  task automatic t_ctrl();
    for (int k = 0; k < 7; k++) begin
      int v0 = vcnt;
      fb[0] = 8'h30 + 8'(k);
      send_frame(1);
      chk(vcnt == v0 + 1, "R3 ctrl count", 64'(vcnt), 64'(v0 + 1));
      expect_req("R3 ctrl", v0, fb[0], 1'b0, 32'd0, 32'd0);
    end
  endtask

  task automatic t_stream_no_update();
    int v0 = vcnt;
    shift_byte(8'h34);
    shift_byte(8'h36);
    repeat (2) @(negedge clk);
    chk(vcnt == v0 + 2, "R2 back-to-back count", 64'(vcnt), 64'(v0 + 2));
    chk(log_sh[v0 + 1] == 1'b1, "R2 valid while shifting", 64'(log_sh[v0 + 1]), 64'd1);
    expect_req("R2 first", v0, 8'h34, 1'b0, 32'd0, 32'd0);
    expect_req("R2 second", v0 + 1, 8'h36, 1'b0, 32'd0, 32'd0);
    end_scan();
  endtask

  task automatic t_mem_read();
    for (int k = 0; k < 3; k++) begin
      int v0 = vcnt;
      fb[0] = 8'h10 + 8'(k);
      fb[1] = 8'h12; fb[2] = 8'h34; fb[3] = 8'h56; fb[4] = 8'h78 + 8'(k);
      send_frame(5);
      chk(vcnt == v0 + 1, "R4 count", 64'(vcnt), 64'(v0 + 1));
      expect_req("R4 read", v0, fb[0], 1'b0, 32'h1234_5678 + 32'(k), 32'd0);
    end
  endtask

  task automatic t_mem_write();
    int v0;
    fb[1] = 8'hDE; fb[2] = 8'hAD; fb[3] = 8'hBE; fb[4] = 8'hEF;
    fb[5] = 8'hA1; fb[6] = 8'hB2; fb[7] = 8'hC3; fb[8] = 8'hD4;
    v0 = vcnt; fb[0] = 8'h18; send_frame(6);
    expect_req("R5 byte", v0, 8'h18, 1'b0, 32'hDEAD_BEEF, 32'h0000_00A1);
    v0 = vcnt; fb[0] = 8'h19; send_frame(7);
    expect_req("R5 half", v0, 8'h19, 1'b0, 32'hDEAD_BEEF, 32'h0000_A1B2);
    v0 = vcnt; fb[0] = 8'h1A; send_frame(9);
    expect_req("R5 word", v0, 8'h1A, 1'b0, 32'hDEAD_BEEF, 32'hA1B2_C3D4);
    chk(vcnt == v0 + 1, "R5 count", 64'(vcnt), 64'(v0 + 1));
  endtask

  task automatic t_reg();
    int v0;
    v0 = vcnt; fb[0] = 8'h20; fb[1] = 8'h9C; send_frame(2);
    expect_req("R6 read", v0, 8'h20, 1'b0, 32'h0000_009C, 32'd0);
    v0 = vcnt; fb[0] = 8'h21; fb[1] = 8'h07;
    fb[2] = 8'h01; fb[3] = 8'h02; fb[4] = 8'h03; fb[5] = 8'h04; send_frame(6);
    expect_req("R6 write", v0, 8'h21, 1'b0, 32'h0000_0007, 32'h0102_0304);
  endtask

  task automatic t_csr();
    int v0;
    // selector = (csr 0x2A << 5) | bank 0x13 = 0x0553
    v0 = vcnt; fb[0] = 8'h22; fb[1] = 8'h05; fb[2] = 8'h53; send_frame(3);
    expect_req("R7 read", v0, 8'h22, 1'b0, 32'h0000_0553, 32'd0);
    @(negedge clk);
    chk(req_bank == 5'h13, "R7 bank", 64'(req_bank), 64'h13);
    chk(req_csr == 11'h2A, "R7 csr", 64'(req_csr), 64'h2A);
    v0 = vcnt; fb[0] = 8'h23; fb[1] = 8'hFF; fb[2] = 8'hE0;
    fb[3] = 8'h55; fb[4] = 8'h66; fb[5] = 8'h77; fb[6] = 8'h88; send_frame(7);
    expect_req("R7 write", v0, 8'h23, 1'b0, 32'h0000_FFE0, 32'h5566_7788);
    @(negedge clk);
    chk(req_bank == 5'h00 && req_csr == 11'h7FF, "R7 write fields",
        64'({req_csr, req_bank}), 64'({11'h7FF, 5'h00}));
  endtask

  task automatic t_unknown();
    int v0 = vcnt;
    fb[0] = 8'hFF; fb[1] = 8'h34; send_frame(2);
    chk(vcnt == v0 + 2, "R8 count", 64'(vcnt), 64'(v0 + 2));
    expect_req("R8 unknown", v0, 8'hFF, 1'b1, 32'd0, 32'd0);
    expect_req("R8 next opcode", v0 + 1, 8'h34, 1'b0, 32'd0, 32'd0);
  endtask

  task automatic t_abort();
    int v0 = vcnt;
    fb[0] = 8'h12; fb[1] = 8'h11; fb[2] = 8'h22; send_frame(3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); shift_en = 1'b1; tdi = 1'b1;
    end
    end_scan();
    chk(vcnt == v0, "R9 no request from cut frame", 64'(vcnt), 64'(v0));
    fb[0] = 8'h10; fb[1] = 8'hCA; fb[2] = 8'hFE; fb[3] = 8'hBA; fb[4] = 8'hBE; send_frame(5);
    chk(vcnt == v0 + 1, "R9 count", 64'(vcnt), 64'(v0 + 1));
    expect_req("R9 realigned", v0, 8'h10, 1'b0, 32'hCAFE_BABE, 32'd0);
  endtask

  task automatic t_deselect();
    int v0 = vcnt;
    dbg_sel = 1'b0;
    fb[0] = 8'h30; send_frame(1);
    dbg_sel = 1'b1;
    chk(vcnt == v0, "R10 ignored while deselected", 64'(vcnt), 64'(v0));
    shift_byte(8'h12);
    shift_byte(8'h44);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); dbg_sel = 1'b0; tdi = 1'b1;
    end
    @(negedge clk); dbg_sel = 1'b1;
    chk(vcnt == v0, "R10 no request from partial", 64'(vcnt), 64'(v0));
    for (int i = 0; i < 8; i++) begin
      tdi = ((8'h35 >> i) & 8'h01) != 0;
      if (i < 7) @(negedge clk);
    end
    end_scan();
    chk(vcnt == v0 + 1, "R10 count", 64'(vcnt), 64'(v0 + 1));
    expect_req("R10 fresh opcode", v0, 8'h35, 1'b0, 32'd0, 32'd0);
  endtask

  task automatic t_hold();
    int v0 = vcnt;
    fb[0] = 8'h20; fb[1] = 8'h5A; send_frame(2);
    repeat (10) @(negedge clk);
    chk(vcnt == v0 + 1, "R11 single pulse", 64'(vcnt), 64'(v0 + 1));
    chk(req_valid == 1'b0, "R11 strobe low", 64'(req_valid), 64'd0);
    chk(req_opcode == 8'h20 && req_sel == 32'h5A, "R11 fields held",
        64'({req_opcode, req_sel}), 64'({8'h20, 32'h5A}));
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    dbg_sel = 1'b1;
    repeat (2) @(negedge clk);
    t_ctrl();
    t_stream_no_update();
    t_mem_read();
    t_mem_write();
    t_reg();
    t_csr();
    t_unknown();
    t_abort();
    t_deselect();
    t_hold();
    finish_run();
  end
endmodule